// File: doc/BRIEF.md
# Prioritised Interrupt Claim Controller

This block collects `NUM_SRC` interrupt lines and presents one interrupt request to a single processor target. Each line is either level-sensitive or rising-edge-sensitive, chosen per source by a parameter mask. Each source has its own priority word and enable bit. The block also has one target threshold. A source takes part in arbitration only when it is pending, enabled and its priority is strictly above the threshold. Among the eligible sources, the one with the highest priority wins; on a tie the lower source ID wins.

Software services an interrupt in two steps. It reads the claim/complete address, which returns the winning ID and moves that source from pending into service. It later writes the same ID back to that address to end service. While a source is in service, further assertions of its line do not set its visible pending bit. They are recorded in a hidden bit that becomes visible pending when the source completes, so an event that arrives during service is not lost. Source ID 0 means "no interrupt".

Register map (word addresses): 0 holds the threshold; 1..`NUM_SRC` hold the priority of source 1..`NUM_SRC`; `NUM_SRC`+1 is the enable bitmap; `NUM_SRC`+2 is the read-only pending bitmap; `NUM_SRC`+3 is the claim/complete address. In both bitmaps, bit i belongs to source i and bit 0 always reads 0. Line `irqIn[i-1]` drives source i. Read data appears on `regRdata` with `regRvalid` one cycle after the read request.

Top module: `intc_claim_ctrl`

## Requirements
- R1: After reset nothing is pending or in service, `irqOut` is 0, and every priority, the threshold and the enable bitmap read 0.
- R2: A source is eligible only if it is pending, its enable bit is 1 and its priority is strictly greater than the threshold; priority 0 is never eligible.
- R3: Among eligible sources the highest priority wins; with equal priorities the lower source ID wins.
- R4: A read of the claim address returns the winning ID, clears that source's pending bit in the same cycle and puts the source in service, so a repeated read returns the next winner or 0.
- R5: A claim read with no eligible source returns 0 and changes neither pending nor in-service state.
- R6: While a source is in service, an assertion of its line does not set its visible pending bit.
- R7: An assertion during service is held in a hidden bit that becomes the visible pending bit when that source's ID is written to the complete address, even if the line has since gone low; a claim clears the hidden bit.
- R8: A complete write whose ID is not a source currently in service (including 0 or an ID above `NUM_SRC`) is ignored.
- R9: An edge-type source becomes pending only on a 0-to-1 transition of its line; a line held high does not re-pend it after completion.
- R10: `irqOut` is 1 exactly when an eligible source exists. It follows priority, enable and threshold writes and claims by the cycle after the write or claim.
- R11: Priority, threshold and enable registers read back what was written; every read request yields `regRvalid` one cycle later; writes to the pending address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqIn | input | NUM_SRC | Interrupt lines; bit i-1 drives source i |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Word address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, one cycle after the request |
| regRvalid | output | 1 | Read data valid |
| irqOut | output | 1 | Interrupt request to the target |

## Verification
The bench builds the block with six sources and a 3-bit priority. Sources 1–3 are level-type and sources 4–6 are edge-type. This makes both gateway variants, equal-priority ties and threshold boundaries reachable within a few dozen register accesses. With this small ID space, out-of-range complete IDs such as 7 can be written directly. A level source held high across a claim exercises the hidden capture. An edge source held high across completion shows that it does not re-trigger.

// File: rtl/intc_claim_pkg.sv
package intc_claim_pkg;
  // Strobes from the access decoder to the datapath
  typedef struct packed {
    logic claim;
    logic complete;
    logic prioWe;
    logic enWe;
    logic thrWe;
    logic rdEn;
  } ctlStrobe_t;
endpackage

// File: rtl/intc_claim_ctl.sv
module intc_claim_ctl
  import intc_claim_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = $clog2(NUM_SRC + 4)
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] ADDR_THR   = '0;
  localparam logic [ADDR_W-1:0] ADDR_EN    = ADDR_W'(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] ADDR_CLAIM = ADDR_W'(NUM_SRC + 3);

  logic isRd, isWr, isPrio;

  always_comb begin
    isRd   = regValid && !regWrite;
    isWr   = regValid && regWrite;
    isPrio = (regAddr != ADDR_THR) && (regAddr <= ADDR_W'(NUM_SRC));
    stb.rdEn     = isRd;
    stb.claim    = isRd && (regAddr == ADDR_CLAIM);
    stb.complete = isWr && (regAddr == ADDR_CLAIM);
    stb.prioWe   = isWr && isPrio;
    stb.enWe     = isWr && (regAddr == ADDR_EN);
    stb.thrWe    = isWr && (regAddr == ADDR_THR);
  end
endmodule

// File: rtl/intc_claim_arb.sv
module intc_claim_arb #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:0]             eligible,
  input  logic [NUM_SRC:0][PRIO_W-1:0] prioVec,
  output logic [ID_W-1:0]              winId
);
  logic [PRIO_W-1:0] bestPrio;

  // Strict compare in ascending ID order keeps the lower ID on ties
  always_comb begin
    winId    = '0;
    bestPrio = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (eligible[i] && (prioVec[i] > bestPrio)) begin
        bestPrio = prioVec[i];
        winId    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_claim_dp.sv
module intc_claim_dp
  import intc_claim_pkg::*;
#(
  parameter int               NUM_SRC   = 8,
  parameter int               PRIO_W    = 3,
  parameter int               DATA_W    = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0,
  parameter int               ADDR_W    = $clog2(NUM_SRC + 4),
  parameter int               ID_W      = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  ctlStrobe_t         stb,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regRvalid,
  output logic               irqOut,
  output logic [NUM_SRC:0]   pendBits,
  output logic [NUM_SRC:0]   hidBits,
  output logic [NUM_SRC:0]   svcBits
);
  localparam logic [ADDR_W-1:0] ADDR_EN    = ADDR_W'(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] ADDR_PEND  = ADDR_W'(NUM_SRC + 2);
  localparam logic [ADDR_W-1:0] ADDR_CLAIM = ADDR_W'(NUM_SRC + 3);

  logic [NUM_SRC:0][PRIO_W-1:0] prioVec;
  logic [NUM_SRC:0]             eligible;
  logic [NUM_SRC:1]             enQ;
  logic [PRIO_W-1:0]            thrQ;
  logic [NUM_SRC-1:0]           irqPrev;
  logic [ID_W-1:0]              winId;
  logic [DATA_W-1:0]            rdMux;

  assign prioVec[0]  = '0;
  assign eligible[0] = 1'b0;
  assign pendBits[0] = 1'b0;
  assign hidBits[0]  = 1'b0;
  assign svcBits[0]  = 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= '0;
      thrQ    <= '0;
      irqPrev <= '0;
    end else begin
      irqPrev <= irqIn;
      if (stb.enWe)  enQ  <= regWdata[NUM_SRC:1];
      if (stb.thrWe) thrQ <= regWdata[PRIO_W-1:0];
    end
  end

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_src
    logic              evt, claimHit, doneHit;
    logic              pendR, hidR, svcR;
    logic [PRIO_W-1:0] prioR;

    if (EDGE_MASK[g-1]) begin : g_edge
      assign evt = irqIn[g-1] & ~irqPrev[g-1];
    end else begin : g_level
      assign evt = irqIn[g-1];
    end

    assign claimHit = stb.claim && (winId == ID_W'(g));
    assign doneHit  = stb.complete && (regWdata == DATA_W'(g)) && svcR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendR <= 1'b0;
        hidR  <= 1'b0;
        svcR  <= 1'b0;
        prioR <= '0;
      end else begin
        if (stb.prioWe && (regAddr == ADDR_W'(g))) prioR <= regWdata[PRIO_W-1:0];
        if (claimHit) begin
          pendR <= 1'b0;
          hidR  <= 1'b0;
          svcR  <= 1'b1;
        end else if (doneHit) begin
          pendR <= pendR | hidR | evt;
          hidR  <= 1'b0;
          svcR  <= 1'b0;
        end else if (svcR) begin
          hidR  <= hidR | evt;
        end else begin
          pendR <= pendR | evt;
        end
      end
    end

    assign prioVec[g]  = prioR;
    assign pendBits[g] = pendR;
    assign hidBits[g]  = hidR;
    assign svcBits[g]  = svcR;
    assign eligible[g] = pendR && enQ[g] && (prioR > thrQ);
  end

  intc_claim_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .eligible (eligible),
    .prioVec  (prioVec),
    .winId    (winId)
  );

  assign irqOut = (winId != '0);

  always_comb begin
    rdMux = '0;
    if (regAddr == '0) rdMux = DATA_W'(thrQ);
    else if (regAddr == ADDR_EN) rdMux = DATA_W'({enQ, 1'b0});
    else if (regAddr == ADDR_PEND) rdMux = DATA_W'(pendBits);
    else if (regAddr == ADDR_CLAIM) rdMux = DATA_W'(winId);
    else begin
      for (int i = 1; i <= NUM_SRC; i++)
        if (regAddr == ADDR_W'(i)) rdMux = DATA_W'(prioVec[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata  <= '0;
      regRvalid <= 1'b0;
    end else begin
      regRvalid <= stb.rdEn;
      if (stb.rdEn) regRdata <= rdMux;
    end
  end
endmodule

// File: rtl/intc_claim_ctrl.sv
module intc_claim_ctrl
  import intc_claim_pkg::*;
#(
  parameter int                 NUM_SRC   = 8,
  parameter int                 PRIO_W    = 3,
  parameter int                 DATA_W    = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0,
  parameter int                 ADDR_W    = $clog2(NUM_SRC + 4),
  parameter int                 ID_W      = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regRvalid,
  output logic               irqOut
);
  ctlStrobe_t     stb;
  logic [NUM_SRC:0] pendBits, hidBits, svcBits;

  intc_claim_ctl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .stb      (stb)
  );

  intc_claim_dp #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
    .EDGE_MASK(EDGE_MASK), .ADDR_W(ADDR_W), .ID_W(ID_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .stb       (stb),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .regRvalid (regRvalid),
    .irqOut    (irqOut),
    .pendBits  (pendBits),
    .hidBits   (hidBits),
    .svcBits   (svcBits)
  );
endmodule

// File: rtl/intc_claim_chk.sv
module intc_claim_chk #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = $clog2(NUM_SRC + 4),
  parameter int ID_W    = $clog2(NUM_SRC + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regValid,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              regRvalid,
  input logic              irqOut,
  input logic [NUM_SRC:0]  pendBits,
  input logic [NUM_SRC:0]  hidBits,
  input logic [NUM_SRC:0]  svcBits
);
  logic claimAcc, doneAcc, doneLegal;
  assign claimAcc  = regValid && !regWrite && (regAddr == ADDR_W'(NUM_SRC + 3));
  assign doneAcc   = regValid && regWrite && (regAddr == ADDR_W'(NUM_SRC + 3));
  assign doneLegal = (regWdata >= 1) && (regWdata <= DATA_W'(NUM_SRC))
                     && svcBits[regWdata[ID_W-1:0]];

  // R4: a successful claim moves the returned source into service
  p_claim_moves_r4: assert property (@(posedge clk) disable iff (!rstN)
    claimAcc && irqOut |=> regRvalid && (regRdata != '0)
      && svcBits[regRdata[ID_W-1:0]] && !pendBits[regRdata[ID_W-1:0]]);

  // R5: empty claim returns zero and leaves service state alone
  p_empty_claim_r5: assert property (@(posedge clk) disable iff (!rstN)
    claimAcc && !irqOut |=> (regRdata == '0) && $stable(svcBits));

  // R6: visible pending never coexists with service
  p_pend_excl_svc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits & svcBits) == '0);

  // R7: hidden capture only exists for in-service sources
  p_hidden_in_svc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hidBits & ~svcBits) == '0);

  // R8: stray completes leave service state unchanged
  p_bad_complete_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneAcc && !doneLegal |=> $stable(svcBits));

  // R11: every read yields valid data a cycle later
  p_read_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    regValid && !regWrite |=> regRvalid);
endmodule

bind intc_claim_ctrl intc_claim_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
  .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
  .regRvalid(regRvalid), .irqOut(irqOut), .pendBits(pendBits),
  .hidBits(hidBits), .svcBits(svcBits)
);

// File: tb/intc_claim_ctrl_tb.sv
module intc_claim_ctrl_tb;
  localparam int N = 6;
  localparam int AW = $clog2(N + 4);
  localparam logic [AW-1:0] A_THR = 0, A_EN = N + 1, A_PEND = N + 2, A_CLM = N + 3;

  logic clk = 0, rstN = 0;
  logic [N-1:0] irq = '0;
  logic regValid = 0, regWrite = 0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic regRvalid, irqOut;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] expVal[$];
  string expTag[$];

  always #2.5 clk = ~clk;

  intc_claim_ctrl #(.NUM_SRC(N), .PRIO_W(3), .DATA_W(32), .EDGE_MASK(6'b111000)) u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irq), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRvalid(regRvalid), .irqOut(irqOut)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1; regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 0; regWrite = 0;
  endtask

  task automatic regRd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    expVal.push_back(exp); expTag.push_back(tag);
    @(negedge clk);
    regValid = 1; regWrite = 0; regAddr = a;
    @(negedge clk);
    regValid = 0;
  endtask

  // Monitor: pop expected read data as the design returns it
  always @(negedge clk) begin
    if (rstN && regRvalid) begin
      if (expVal.size() == 0) check(regRdata, 32'hdead, "R11 unexpected read data");
      else check(regRdata, expVal.pop_front(), expTag.pop_front());
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(irqOut, 0, "R1 irqOut after reset");
    regRd(A_PEND, 0, "R1 pending after reset");
    regRd(1, 0, "R1 priority after reset");
    regRd(A_CLM, 0, "R5 empty claim after reset");

    regWr(1, 2); regWr(2, 5); regWr(3, 5); regWr(4, 1); regWr(5, 3); regWr(6, 0);
    regWr(A_THR, 1); regWr(A_EN, 32'h7E);
    regRd(2, 5, "R11 priority readback");
    regRd(A_EN, 32'h7E, "R11 enable readback");
    regRd(A_THR, 1, "R11 threshold readback");

    @(negedge clk); irq[0] = 1; irq[3] = 1;
    @(negedge clk);
    check(irqOut, 1, "R10 irqOut on eligible level source");
    regRd(A_PEND, 32'h12, "R9 pending from level and edge");
    regRd(A_CLM, 1, "R4 claim returns src1");
    regRd(A_PEND, 32'h10, "R6 held src1 not re-pended in service");
    regRd(A_CLM, 0, "R2 src4 prio equal threshold not eligible");
    @(negedge clk);
    check(irqOut, 0, "R2 irqOut low below threshold");

    regWr(A_THR, 0);
    check(irqOut, 1, "R10 irqOut after threshold drop");
    @(negedge clk); irq[0] = 0;
    regWr(A_CLM, 1);
    regRd(A_PEND, 32'h12, "R7 hidden released on complete");

    @(negedge clk); irq[1] = 1; irq[2] = 1;
    @(negedge clk);
    regRd(A_CLM, 2, "R3 tie goes to lower ID");
    regRd(A_CLM, 3, "R3 second of tie");
    regRd(A_CLM, 1, "R3 higher priority before lower");
    regRd(A_CLM, 4, "R4 last remaining");
    regRd(A_CLM, 0, "R4 repeat claim empty");
    @(negedge clk); irq[1] = 0; irq[2] = 0;
    regRd(A_PEND, 0, "R6 nothing visible while all in service");
    regWr(A_CLM, 3);
    regRd(A_PEND, 32'h08, "R7 src3 released after complete");

    regWr(A_CLM, 5); regWr(A_CLM, 7); regWr(A_CLM, 0);
    regRd(A_PEND, 32'h08, "R8 stray completes ignored");
    regWr(A_CLM, 2);
    regRd(A_PEND, 32'h0C, "R8 src2 still in service then released");

    regWr(A_CLM, 4); regWr(A_CLM, 1);
    regRd(A_PEND, 32'h0C, "R9 held edge line does not re-pend");
    @(negedge clk); irq[3] = 0;
    @(negedge clk); irq[3] = 1;
    @(negedge clk);
    regRd(A_PEND, 32'h1C, "R9 fresh rising edge pends");

    regWr(A_EN, 32'h10);
    check(irqOut, 1, "R10 only src4 enabled");
    regWr(4, 0);
    check(irqOut, 0, "R10 priority write to 0 drops irqOut");
    regRd(A_CLM, 0, "R2 priority 0 never claimed");
    regRd(A_PEND, 32'h1C, "R5 empty claim leaves pending");

    regWr(A_EN, 32'h0C); regWr(A_THR, 5);
    check(irqOut, 0, "R2 priority equal to threshold");
    regWr(A_THR, 4);
    check(irqOut, 1, "R2 priority above threshold");
    regRd(A_CLM, 2, "R4 claim after threshold change");
    regWr(A_PEND, 0);
    regRd(A_PEND, 32'h18, "R11 pending write ignored");

    repeat (3) @(negedge clk);
    check(expVal.size(), 0, "R11 all reads returned");
    finished = 1;
    summary();
    $finish;
  end
endmodule